// File: doc/BRIEF.md
# Monochrome EL Panel Video Driver

This block produces the video stream for a 640x200 monochrome electroluminescent panel. Each pixel-clock cycle carries a group of four adjacent pixels on a 4-bit bus. A line sync pulse follows the last group of every row. A frame sync pulse surrounds the line sync that closes the top row of the frame, so the frame sync marks the end of the first line, not the start of the frame. Pixel groups arrive from an upstream source over a ready/valid handshake. The block has no pixel storage.

Every minimum time is a parameter given in nanoseconds. The block rounds each one up to whole system-clock cycles. It then combines them into five phase lengths: VCLK high (H), VCLK low after a handshake (L), the gap from the last VCLK fall to the HS rise (P), HS high (S), and HS low (Q). The pixel clock stays low whenever the sync lines move. If the source runs dry, the pixel clock stalls low with no glitch. A blank request takes effect only at a frame boundary. While blanked, all outputs are parked low, which blanks the panel or lets it enter standby. When the request is withdrawn, output restarts at the top row.

Top module: `el_video_drv`

## Requirements
- R1: While reset is high, vclk_o, hs_o and vs_o are 0, vid_o is 0 and pix_ready_o is 1. After reset, output starts with the first group of row 0.
- R2: pix_ready_o is 1 only while the driver waits for the next group, with vclk_o, hs_o and vs_o all 0. Exactly one group is taken per cycle in which pix_ready_o and pix_valid_i are both 1.
- R3: vid_o takes pix_data_i on the clock edge that completes a handshake. vclk_o then stays 0 for exactly L cycles before it rises, where L = max(ceil(lo), ceil(setup), ceil(period) - H - 1).
- R4: vclk_o is high for exactly H = max(ceil(high), ceil(hold)) cycles, and vid_o is stable during that time. Each pixel-clock period is therefore at least 1 + L + H cycles.
- R5: While pix_valid_i is 0 during a wait, vclk_o stays 0 and pix_ready_o stays 1 on every cycle.
- R6: After NIBBLES groups, vclk_o stays 0 and pix_ready_o stays 0 for P cycles, where P = max(ceil(HS-to-VCLK), ceil(VS-low setup)). hs_o is then 1 for S = max(ceil(HS high), ceil(VS setup) - P) cycles. hs_o is then 0 for Q = max(ceil(HS low), ceil(VS hold), ceil(HS-to-VCLK)) cycles before the next row starts.
- R7: On row 0 only, vs_o is 1 from the first cycle of P through the last cycle of Q. This gives at least P + S cycles of setup before the HS fall and Q cycles of hold after it.
- R8: On every row other than row 0, vs_o stays 0. This keeps vs_o low for at least P cycles before every HS rise that does not belong to row 0.
- R9: A frame is LINES rows. After the last row, the next row is row 0 again, and its line sync carries vs_o.
- R10: blank_i is sampled on the last cycle of the final row's HS low phase. If it is 1 there, all outputs go to 0 and pix_ready_o goes to 0 until blank_i is 0, and output then resumes at row 0 with vid_o still 0. A blank request withdrawn before that cycle has no effect.
- R11: pix_valid_i and pix_data_i have no effect while pix_ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid_i | input | 1 | Source offers a pixel group |
| pix_ready_o | output | 1 | Driver accepts a pixel group this cycle |
| pix_data_i | input | 4 | Four adjacent pixels, one bit each |
| blank_i | input | 1 | Request to blank the panel from the next frame boundary |
| vclk_o | output | 1 | Pixel clock to the panel |
| hs_o | output | 1 | Line sync, pulsed after each row |
| vs_o | output | 1 | Frame sync, around the line sync of row 0 |
| vid_o | output | 4 | Pixel group driven to the panel |

## Verification
All outputs are registered, so each result appears one clock edge after the cycle whose state and inputs cause it. The handshake edge updates vid_o at once. vclk_o rises L edges later and falls H edges after that. The line sync phases follow back to back from the last VCLK fall. The bench model walks the expected waveform one clock at a time and drives the source and the blank request itself, so it knows the edge at which each change is due. It compares every output at the falling clock edge, midway between the edge that updates the registers and the edge that samples the inputs.

// File: rtl/el_drv_pkg.sv
`timescale 1ns/1ps
package el_drv_pkg;

    localparam int VID_W = 4;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_PRE,
        ST_HSH,
        ST_HSL,
        ST_BLANK
    } drv_state_t;

    typedef struct packed {
        logic             vclk;
        logic             hs;
        logic             vs;
        logic [VID_W-1:0] vid;
    } panel_out_t;

    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // VCLK high phase: covers both high width and data hold
    function automatic int len_hi(input int c, input int hi, input int hd);
        return imax(imax(ns2cyc(hi, c), ns2cyc(hd, c)), 1);
    endfunction

    // VCLK low phase after the capture cycle: low width, setup, full period
    function automatic int len_lo(input int c, input int lo, input int su,
                                  input int per, input int hi, input int hd);
        return imax(imax(imax(ns2cyc(lo, c), ns2cyc(su, c)),
                         ns2cyc(per, c) - len_hi(c, hi, hd) - 1), 1);
    endfunction

    function automatic int len_pre(input int c, input int h2c, input int vsl);
        return imax(imax(ns2cyc(h2c, c), ns2cyc(vsl, c)), 1);
    endfunction

    function automatic int len_hsh(input int c, input int hsh, input int vssu,
                                   input int h2c, input int vsl);
        return imax(imax(ns2cyc(hsh, c), ns2cyc(vssu, c) - len_pre(c, h2c, vsl)), 1);
    endfunction

    function automatic int len_hsl(input int c, input int hsl, input int vshd,
                                   input int h2c);
        return imax(imax(imax(ns2cyc(hsl, c), ns2cyc(vshd, c)), ns2cyc(h2c, c)), 1);
    endfunction

endpackage

// File: rtl/el_phase_timer.sv
`timescale 1ns/1ps
module el_phase_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/el_wrap_ctr.sv
`timescale 1ns/1ps
module el_wrap_ctr #(
    parameter int COUNT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    output logic last
);
    localparam int W = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic [W-1:0] val;

    always_ff @(posedge clk) begin
        if (rst) begin
            val <= '0;
        end else if (inc) begin
            val <= last ? '0 : val + 1'b1;
        end
    end

    assign last = (val == W'(COUNT - 1));
endmodule

// File: rtl/el_video_drv.sv
`timescale 1ns/1ps
module el_video_drv
    import el_drv_pkg::*;
#(
    parameter int CLK_NS        = 5,
    parameter int NIBBLES       = 160,
    parameter int LINES         = 200,
    parameter int T_VCLK_LO_NS  = 125,
    parameter int T_VCLK_HI_NS  = 125,
    parameter int T_VCLK_PER_NS = 334,
    parameter int T_VID_SU_NS   = 100,
    parameter int T_VID_HD_NS   = 100,
    parameter int T_HS_HI_NS    = 125,
    parameter int T_HS_LO_NS    = 160,
    parameter int T_HS2CLK_NS   = 63,
    parameter int T_VS_SU_NS    = 100,
    parameter int T_VS_HD_NS    = 100,
    parameter int T_VSL_SU_NS   = 140
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid_i,
    output logic             pix_ready_o,
    input  logic [VID_W-1:0] pix_data_i,
    input  logic             blank_i,
    output logic             vclk_o,
    output logic             hs_o,
    output logic             vs_o,
    output logic [VID_W-1:0] vid_o
);
    localparam int H_LEN   = len_hi(CLK_NS, T_VCLK_HI_NS, T_VID_HD_NS);
    localparam int L_LEN   = len_lo(CLK_NS, T_VCLK_LO_NS, T_VID_SU_NS, T_VCLK_PER_NS,
                                    T_VCLK_HI_NS, T_VID_HD_NS);
    localparam int PRE_LEN = len_pre(CLK_NS, T_HS2CLK_NS, T_VSL_SU_NS);
    localparam int HSH_LEN = len_hsh(CLK_NS, T_HS_HI_NS, T_VS_SU_NS, T_HS2CLK_NS, T_VSL_SU_NS);
    localparam int HSL_LEN = len_hsl(CLK_NS, T_HS_LO_NS, T_VS_HD_NS, T_HS2CLK_NS);
    localparam int MAXLEN  = imax(imax(H_LEN, L_LEN), imax(PRE_LEN, imax(HSH_LEN, HSL_LEN)));
    localparam int TW      = $clog2(MAXLEN + 1);

    drv_state_t    state, nxt;
    panel_out_t    out_q;
    logic          t_load, t_done;
    logic [TW-1:0] t_val;
    logic          nib_inc, nib_last;
    logic          line_inc, line_last;
    logic          line_first;
    logic          take;
    logic          vs_win;

    el_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    el_wrap_ctr #(.COUNT(NIBBLES)) u_nib_ctr (
        .clk  (clk),
        .rst  (rst),
        .inc  (nib_inc),
        .last (nib_last)
    );

    el_wrap_ctr #(.COUNT(LINES)) u_line_ctr (
        .clk  (clk),
        .rst  (rst),
        .inc  (line_inc),
        .last (line_last)
    );

    // Sequencer: one group per FETCH->LOW->HIGH pass, sync phases at row end
    always_comb begin
        nxt      = state;
        t_load   = 1'b0;
        t_val    = '0;
        nib_inc  = 1'b0;
        line_inc = 1'b0;
        take     = 1'b0;
        case (state)
            ST_FETCH: begin
                if (pix_valid_i) begin
                    take   = 1'b1;
                    nxt    = ST_LOW;
                    t_load = 1'b1;
                    t_val  = TW'(L_LEN - 1);
                end
            end
            ST_LOW: begin
                if (t_done) begin
                    nxt    = ST_HIGH;
                    t_load = 1'b1;
                    t_val  = TW'(H_LEN - 1);
                end
            end
            ST_HIGH: begin
                if (t_done) begin
                    nib_inc = 1'b1;
                    if (nib_last) begin
                        nxt    = ST_PRE;
                        t_load = 1'b1;
                        t_val  = TW'(PRE_LEN - 1);
                    end else begin
                        nxt = ST_FETCH;
                    end
                end
            end
            ST_PRE: begin
                if (t_done) begin
                    nxt    = ST_HSH;
                    t_load = 1'b1;
                    t_val  = TW'(HSH_LEN - 1);
                end
            end
            ST_HSH: begin
                if (t_done) begin
                    nxt    = ST_HSL;
                    t_load = 1'b1;
                    t_val  = TW'(HSL_LEN - 1);
                end
            end
            ST_HSL: begin
                if (t_done) begin
                    line_inc = 1'b1;
                    nxt      = (line_last && blank_i) ? ST_BLANK : ST_FETCH;
                end
            end
            ST_BLANK: begin
                if (!blank_i) begin
                    nxt = ST_FETCH;
                end
            end
            default: nxt = ST_FETCH;
        endcase
    end

    assign vs_win = (nxt == ST_PRE) || (nxt == ST_HSH) || (nxt == ST_HSL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_FETCH;
            out_q      <= '0;
            line_first <= 1'b1;
        end else begin
            state      <= nxt;
            out_q.vclk <= (nxt == ST_HIGH);
            out_q.hs   <= (nxt == ST_HSH);
            out_q.vs   <= vs_win && line_first;
            if (take) begin
                out_q.vid <= pix_data_i;
            end else if (nxt == ST_BLANK) begin
                out_q.vid <= '0;
            end
            if (line_inc) begin
                line_first <= line_last;
            end
        end
    end

    assign pix_ready_o = (state == ST_FETCH);
    assign vclk_o      = out_q.vclk;
    assign hs_o        = out_q.hs;
    assign vs_o        = out_q.vs;
    assign vid_o       = out_q.vid;
endmodule

// File: rtl/el_video_drv_chk.sv
`timescale 1ns/1ps
module el_video_drv_chk (
    input logic       clk,
    input logic       rst,
    input logic       pix_valid_i,
    input logic       pix_ready_o,
    input logic       vclk_o,
    input logic       hs_o,
    input logic       vs_o,
    input logic [3:0] vid_o
);
    // R4
    vid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        vclk_o |-> $stable(vid_o));

    // R3
    vid_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vclk_o) |-> !$past(pix_ready_o));

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pix_ready_o |-> (!vclk_o && !hs_o && !vs_o));

    // R5
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_ready_o && !pix_valid_i) |=> (pix_ready_o && !vclk_o));

    // R6
    hs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        hs_o |-> (!vclk_o && !pix_ready_o));

    // R7
    vs_setup_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(hs_o) && vs_o) |-> $past(vs_o));

    // R7
    vs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vs_o) |-> (!hs_o && !$past(hs_o)));
endmodule

bind el_video_drv el_video_drv_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pix_valid_i (pix_valid_i),
    .pix_ready_o (pix_ready_o),
    .vclk_o      (vclk_o),
    .hs_o        (hs_o),
    .vs_o        (vs_o),
    .vid_o       (vid_o)
);

// File: tb/tb_el_video_drv.sv
`timescale 1ns/1ps
module tb_el_video_drv;

    localparam int CLK_NS = 5;
    localparam int NIB    = 6;
    localparam int LIN    = 3;
    localparam int T_LO = 15, T_HI = 8, T_PER = 33, T_SU = 12, T_HD = 6;
    localparam int T_HSH = 10, T_HSL = 14, T_H2C = 4, T_VSSU = 18, T_VSHD = 22, T_VSL = 12;

    function automatic int cyc(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int H_EXP = mx(cyc(T_HI), cyc(T_HD));
    localparam int L_EXP = mx(mx(cyc(T_LO), cyc(T_SU)), cyc(T_PER) - H_EXP - 1);
    localparam int P_EXP = mx(cyc(T_H2C), cyc(T_VSL));
    localparam int S_EXP = mx(cyc(T_HSH), cyc(T_VSSU) - P_EXP);
    localparam int Q_EXP = mx(mx(cyc(T_HSL), cyc(T_VSHD)), cyc(T_H2C));

    logic       clk = 1'b0;
    logic       rst;
    logic       pix_valid;
    logic [3:0] pix_data;
    logic       blank;
    logic       rdy, vclk, hs, vs;
    logic [3:0] vid;
    logic [3:0] prev;
    int         tests = 0;
    int         fails = 0;
    bit         done  = 1'b0;

    always #2.5 clk = ~clk;

    el_video_drv #(
        .CLK_NS(CLK_NS), .NIBBLES(NIB), .LINES(LIN),
        .T_VCLK_LO_NS(T_LO), .T_VCLK_HI_NS(T_HI), .T_VCLK_PER_NS(T_PER),
        .T_VID_SU_NS(T_SU), .T_VID_HD_NS(T_HD),
        .T_HS_HI_NS(T_HSH), .T_HS_LO_NS(T_HSL), .T_HS2CLK_NS(T_H2C),
        .T_VS_SU_NS(T_VSSU), .T_VS_HD_NS(T_VSHD), .T_VSL_SU_NS(T_VSL)
    ) dut (
        .clk(clk), .rst(rst), .pix_valid_i(pix_valid), .pix_ready_o(rdy),
        .pix_data_i(pix_data), .blank_i(blank), .vclk_o(vclk), .hs_o(hs),
        .vs_o(vs), .vid_o(vid)
    );

    task automatic chk(input string tag, input logic ev, input logic eh, input logic es,
                       input logic [3:0] ed, input logic er);
        tests++;
        if (vclk !== ev || hs !== eh || vs !== es || vid !== ed || rdy !== er) begin
            fails++;
            $display("FAIL %s at %0t: vclk/hs/vs/vid/ready got %b %b %b %h %b expected %b %b %b %h %b",
                     tag, $time, vclk, hs, vs, vid, rdy, ev, eh, es, ed, er);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_line(input int f, input int l);
        logic       vx;
        logic [3:0] d;
        int         st;
        vx = (l == 0);
        for (int n = 0; n < NIB; n++) begin
            d  = 4'(n * 5 + l * 3 + f * 7 + 1);
            st = ((n + l + f) % 3 == 0) ? 2 : 0;
            repeat (st) begin
                chk("R5", 1'b0, 1'b0, 1'b0, prev, 1'b1);
                pix_valid = 1'b0; pix_data = ~d;
                tick();
            end
            chk("R2", 1'b0, 1'b0, 1'b0, prev, 1'b1);
            pix_valid = 1'b1; pix_data = d;
            tick();
            for (int k = 0; k < L_EXP; k++) begin
                chk((k == 0) ? "R3" : "R11", 1'b0, 1'b0, 1'b0, d, 1'b0);
                pix_valid = 1'b1; pix_data = ~d;
                tick();
            end
            for (int k = 0; k < H_EXP; k++) begin
                chk("R4", 1'b1, 1'b0, 1'b0, d, 1'b0);
                pix_valid = 1'b1; pix_data = ~d;
                tick();
            end
            prev = d;
        end
        for (int k = 0; k < P_EXP; k++) begin
            chk(vx ? ((f > 0) ? "R9" : "R7") : "R8", 1'b0, 1'b0, vx, prev, 1'b0);
            pix_valid = 1'b0;
            tick();
        end
        for (int k = 0; k < S_EXP; k++) begin
            chk("R6", 1'b0, 1'b1, vx, prev, 1'b0);
            tick();
        end
        for (int k = 0; k < Q_EXP; k++) begin
            chk(vx ? "R7" : "R6", 1'b0, 1'b0, vx, prev, 1'b0);
            tick();
        end
    endtask

    task automatic do_frame(input int f);
        for (int l = 0; l < LIN; l++) begin
            if (f == 1 && l == 0)       blank = 1'b1;  // R10: withdrawn before frame end
            if (f == 1 && l == LIN - 1) blank = 1'b0;
            if (f == 2 && l == LIN - 1) blank = 1'b1;  // R10: held through frame end
            do_line(f, l);
        end
        if (f == 2) begin
            for (int k = 0; k < 10; k++) begin
                chk("R10", 1'b0, 1'b0, 1'b0, 4'h0, 1'b0);
                pix_valid = 1'b1; pix_data = 4'hA;
                if (k == 9) blank = 1'b0;
                tick();
            end
            prev = 4'h0;
        end
    endtask

    initial begin
        rst = 1'b1; pix_valid = 1'b0; pix_data = 4'h0; blank = 1'b0; prev = 4'h0;
        repeat (3) @(posedge clk);
        tick();
        chk("R1", 1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
        rst = 1'b0;
        for (int f = 0; f < 4; f++) begin
            do_frame(f);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R9: got no frame completion, expected run to end");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule